// File: doc/BRIEF.md
# Selectable ADC Conversion Trigger with Delay

This block takes the synchronisation events of a motor-control datapath and sends them to two consumers. The events are the minimum and maximum points of a two-level PWM carrier and of a three-level PWM carrier, plus the completion strobe of a data mover. All of them are gathered into one registered interrupt vector that goes to the processor interrupt lines.

A small source code, written by software, picks one event, or one pair of events, to start an ADC conversion. That start pulse can be held back by a programmed number of clock cycles. This keeps the sampling instant clear of the switching edges that gate drivers and power switches produce after the PWM event. A debug input fires the delayed start path whatever source is selected. Only the conversion-start path is delayed; the interrupt vector always follows the events by one clock.

Top module: `adc_trig_router`

## Requirements
- R1: A synchronous active-high reset clears any running countdown and holds `irq_vec_o` and `adc_start_o` low; no pulse left over from before the reset appears afterwards.
- R2: `irq_vec_o` is the registered copy of the event inputs, one clock after them. The bit order is: bit 0 two-level minimum, bit 1 two-level maximum, bit 2 three-level minimum, bit 3 three-level maximum, bit 4 data-mover done. Bit 0 maps to the lowest interrupt ID.
- R3: Select code 0 triggers on the two-level carrier minimum and maximum, code 1 on the minimum only and code 2 on the maximum only.
- R4: Select code 3 triggers on the three-level carrier minimum and maximum, code 4 on the minimum only and code 5 on the maximum only.
- R5: Select code 6 triggers on the data-mover done strobe only.
- R6: Select code 7 produces no conversion start from any event input.
- R7: With a delay value of 0, `adc_start_o` is a one-clock pulse in the clock after the selected event, aligned with the matching interrupt bit.
- R8: With a delay value N greater than 0, `adc_start_o` is a one-clock pulse exactly N+1 clocks after the selected event.
- R9: A selected event that arrives while a countdown runs restarts the countdown from that event. Only the pulse for the newest event is produced.
- R10: The select code and the delay value are taken only while no countdown runs. Changes made during a countdown have no effect on it and apply from the next idle cycle.
- R11: `dbg_fire_i` starts the delay path like a selected event, under any select code including 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm2_min_i | input | 1 | Two-level carrier minimum, one-clock pulse |
| pwm2_max_i | input | 1 | Two-level carrier maximum, one-clock pulse |
| pwm3_min_i | input | 1 | Three-level carrier minimum, one-clock pulse |
| pwm3_max_i | input | 1 | Three-level carrier maximum, one-clock pulse |
| dm_done_i | input | 1 | Data-mover write completion, one-clock pulse |
| dbg_fire_i | input | 1 | Manual trigger of the delay path |
| src_sel_i | input | 3 | Conversion-start source code (0..6, 7 = none) |
| dly_cyc_i | input | 16 | Delay in clock cycles |
| irq_vec_o | output | 5 | Registered interrupt vector |
| adc_start_o | output | 1 | Delayed conversion-start pulse |

## Verification
Every interrupt bit is due in the clock after its event, and the conversion start is due N+1 clocks after the event that loaded or last restarted the countdown. The driver turns each stimulus into a due cycle, using the configuration the block must have captured: the live value when idle, the held value during a countdown. The monitor compares each cycle, sampled at the falling edge, against the head of the queue. A pulse in any cycle that is not due, or a missing pulse in a due cycle, is reported. Stimuli that must not trigger are also followed by quiet windows that cover the delay in force.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  localparam int EVT_N = 5;
  localparam int SEL_W = 3;

  // event vector bit positions (also interrupt line order)
  localparam int EV_P2_MIN = 0;
  localparam int EV_P2_MAX = 1;
  localparam int EV_P3_MIN = 2;
  localparam int EV_P3_MAX = 3;
  localparam int EV_DM     = 4;

  typedef enum logic [SEL_W-1:0] {
    SRC_2L_BOTH = 3'd0,
    SRC_2L_MIN  = 3'd1,
    SRC_2L_MAX  = 3'd2,
    SRC_3L_BOTH = 3'd3,
    SRC_3L_MIN  = 3'd4,
    SRC_3L_MAX  = 3'd5,
    SRC_DM      = 3'd6,
    SRC_NONE    = 3'd7
  } src_e;

  function automatic logic [EVT_N-1:0] src_mask(input logic [SEL_W-1:0] code);
    logic [EVT_N-1:0] m;
    m = '0;
    case (src_e'(code))
      SRC_2L_BOTH: begin m[EV_P2_MIN] = 1'b1; m[EV_P2_MAX] = 1'b1; end
      SRC_2L_MIN:  m[EV_P2_MIN] = 1'b1;
      SRC_2L_MAX:  m[EV_P2_MAX] = 1'b1;
      SRC_3L_BOTH: begin m[EV_P3_MIN] = 1'b1; m[EV_P3_MAX] = 1'b1; end
      SRC_3L_MIN:  m[EV_P3_MIN] = 1'b1;
      SRC_3L_MAX:  m[EV_P3_MAX] = 1'b1;
      SRC_DM:      m[EV_DM] = 1'b1;
      default:     m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/evt_vector_pack.sv
module evt_vector_pack #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] vec_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) vec_o[i] <= 1'b0;
      else     vec_o[i] <= evt_i[i];
    end
  end

endmodule

// File: rtl/trig_src_select.sv
module trig_src_select
  import adc_trig_pkg::*;
(
  input  logic [SEL_W-1:0] code_i,
  input  logic [EVT_N-1:0] evt_i,
  input  logic             dbg_i,
  output logic             hit_o
);

  logic [EVT_N-1:0] mask;

  always_comb begin
    mask  = src_mask(code_i);
    hit_o = (|(mask & evt_i)) | dbg_i;
  end

endmodule

// File: rtl/trig_delay_line.sv
module trig_delay_line #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit_i,
  input  logic [W-1:0] dly_i,
  output logic         fire_o,
  output logic         busy_o,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fire_o <= 1'b0;
      busy_o <= 1'b0;
      cnt_o  <= '0;
    end else begin
      fire_o <= 1'b0;
      if (hit_i) begin
        if (dly_i == '0) begin
          fire_o <= 1'b1;
          busy_o <= 1'b0;
          cnt_o  <= '0;
        end else begin
          busy_o <= 1'b1;
          cnt_o  <= dly_i;
        end
      end else if (busy_o) begin
        if (cnt_o == ONE) begin
          fire_o <= 1'b1;
          busy_o <= 1'b0;
          cnt_o  <= '0;
        end else begin
          cnt_o <= cnt_o - ONE;
        end
      end
    end
  end

endmodule

// File: rtl/adc_trig_router.sv
module adc_trig_router
  import adc_trig_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm2_min_i,
  input  logic             pwm2_max_i,
  input  logic             pwm3_min_i,
  input  logic             pwm3_max_i,
  input  logic             dm_done_i,
  input  logic             dbg_fire_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic [DLY_W-1:0] dly_cyc_i,
  output logic [EVT_N-1:0] irq_vec_o,
  output logic             adc_start_o
);

  logic [EVT_N-1:0] evt_w;
  logic [SEL_W-1:0] sel_hold, sel_eff;
  logic [DLY_W-1:0] dly_hold, dly_eff;
  logic             hit_w, busy_w;
  logic [DLY_W-1:0] cnt_w;

  always_comb begin
    evt_w            = '0;
    evt_w[EV_P2_MIN] = pwm2_min_i;
    evt_w[EV_P2_MAX] = pwm2_max_i;
    evt_w[EV_P3_MIN] = pwm3_min_i;
    evt_w[EV_P3_MAX] = pwm3_max_i;
    evt_w[EV_DM]     = dm_done_i;
  end

  // configuration is captured on every idle cycle and frozen during a countdown
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_hold <= SRC_NONE;
      dly_hold <= '0;
    end else if (!busy_w) begin
      sel_hold <= src_sel_i;
      dly_hold <= dly_cyc_i;
    end
  end

  always_comb begin
    sel_eff = busy_w ? sel_hold : src_sel_i;
    dly_eff = busy_w ? dly_hold : dly_cyc_i;
  end

  evt_vector_pack #(.N(EVT_N)) u_pack (
    .clk   (clk),
    .rst   (rst),
    .evt_i (evt_w),
    .vec_o (irq_vec_o)
  );

  trig_src_select u_sel (
    .code_i (sel_eff),
    .evt_i  (evt_w),
    .dbg_i  (dbg_fire_i),
    .hit_o  (hit_w)
  );

  trig_delay_line #(.W(DLY_W)) u_dly (
    .clk    (clk),
    .rst    (rst),
    .hit_i  (hit_w),
    .dly_i  (dly_eff),
    .fire_o (adc_start_o),
    .busy_o (busy_w),
    .cnt_o  (cnt_w)
  );

endmodule

// File: rtl/adc_trig_router_chk.sv
module adc_trig_router_chk
  import adc_trig_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [EVT_N-1:0] evt,
  input logic             dbg_fire_i,
  input logic [SEL_W-1:0] src_sel_i,
  input logic [DLY_W-1:0] dly_cyc_i,
  input logic             hit,
  input logic             busy,
  input logic [DLY_W-1:0] cnt,
  input logic [EVT_N-1:0] irq_vec_o,
  input logic             adc_start_o
);

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always_ff @(negedge clk) begin
    if (rst_q && rst) begin
      reset_clear_chk: assert (irq_vec_o == '0 && adc_start_o == 1'b0);
    end
  end

  for (genvar i = 0; i < EVT_N; i++) begin : g_vec
    // R2
    vec_map_chk: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> irq_vec_o[i]);
  end

  // R7
  zero_dly_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !busy && dly_cyc_i == '0) |=> adc_start_o);

  // R8
  expire_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !hit && cnt == DLY_W'(1)) |=> adc_start_o);

  // R6
  no_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && src_sel_i == 3'd7 && !dbg_fire_i) |=> !adc_start_o);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && hit) |=> (!adc_start_o && busy));

endmodule

bind adc_trig_router adc_trig_router_chk #(.DLY_W(DLY_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .evt         (evt_w),
  .dbg_fire_i  (dbg_fire_i),
  .src_sel_i   (src_sel_i),
  .dly_cyc_i   (dly_cyc_i),
  .hit         (hit_w),
  .busy        (busy_w),
  .cnt         (cnt_w),
  .irq_vec_o   (irq_vec_o),
  .adc_start_o (adc_start_o)
);

// File: tb/adc_trig_router_test.sv
module adc_trig_router_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwm2_min_i = 0, pwm2_max_i = 0, pwm3_min_i = 0, pwm3_max_i = 0;
  logic        dm_done_i = 0, dbg_fire_i = 0;
  logic [2:0]  src_sel_i = 3'd7;
  logic [15:0] dly_cyc_i = '0;
  logic [4:0]  irq_vec_o;
  logic        adc_start_o;

  adc_trig_router uut (
    .clk(clk), .rst(rst),
    .pwm2_min_i(pwm2_min_i), .pwm2_max_i(pwm2_max_i),
    .pwm3_min_i(pwm3_min_i), .pwm3_max_i(pwm3_max_i),
    .dm_done_i(dm_done_i), .dbg_fire_i(dbg_fire_i),
    .src_sel_i(src_sel_i), .dly_cyc_i(dly_cyc_i),
    .irq_vec_o(irq_vec_o), .adc_start_o(adc_start_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int due; string tag; } exp_t;
  exp_t q[$];

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  logic [2:0]  lat_s = 3'd7;
  int          lat_d = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // event bits: [0] 2L min, [1] 2L max, [2] 3L min, [3] 3L max, [4] data-mover done
  function automatic logic [4:0] want_mask(input logic [2:0] s);
    case (s)
      3'd0: return 5'b00011;
      3'd1: return 5'b00001;
      3'd2: return 5'b00010;
      3'd3: return 5'b01100;
      3'd4: return 5'b00100;
      3'd5: return 5'b01000;
      3'd6: return 5'b10000;
      default: return 5'b00000;
    endcase
  endfunction

  // monitor: compares conversion-start pulses against the due queue
  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        checks++;
        if (!adc_start_o) begin
          fails++;
          $display("FAIL %s: adc_start_o at cycle %0d actual 0 expected 1", q[0].tag, cyc);
        end
        void'(q.pop_front());
      end else if (adc_start_o) begin
        checks++;
        fails++;
        $display("FAIL R9: adc_start_o at cycle %0d actual 1 expected 0 (no pulse due)", cyc);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] s, input int d);
    @(negedge clk);
    src_sel_i = s;
    dly_cyc_i = 16'(d);
  endtask

  // b: [5] debug fire, [4:0] event bits as in want_mask
  task automatic ev(input logic [5:0] b, input string tag);
    bit bz;
    logic [2:0] s;
    int d;
    bit fires;
    @(negedge clk);
    bz = (q.size() > 0) && (q[q.size()-1].due > cyc);
    s  = bz ? lat_s : src_sel_i;
    d  = bz ? lat_d : int'(dly_cyc_i);
    fires = b[5] || ((want_mask(s) & b[4:0]) != 5'b0);
    {dbg_fire_i, dm_done_i, pwm3_max_i, pwm3_min_i, pwm2_max_i, pwm2_min_i} = b;
    if (fires) begin
      if (bz) void'(q.pop_back());
      else begin
        lat_s = src_sel_i;
        lat_d = int'(dly_cyc_i);
      end
      q.push_back('{cyc + 1 + d, tag});
    end
    @(negedge clk);
    {dbg_fire_i, dm_done_i, pwm3_max_i, pwm3_min_i, pwm2_max_i, pwm2_min_i} = '0;
    // R2: vector is the events one clock later
    chk(irq_vec_o == b[4:0], "R2 irq_vec_o", int'(irq_vec_o), int'(b[4:0]));
  endtask

  task automatic quiet(input int n, input string tag);
    bit bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (adc_start_o) bad = 1;
    end
    chk(!bad, tag, int'(bad), 0);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    settle(3);
    // R1: outputs held low in reset
    chk(irq_vec_o == 5'b0 && adc_start_o == 1'b0, "R1 reset outputs",
        int'({irq_vec_o, adc_start_o}), 0);
    rst = 1'b0;
    settle(2);

    // R1: reset during a countdown drops the pending pulse
    cfg(3'd1, 20);
    ev(6'b000001, "R1");
    settle(3);
    @(negedge clk);
    rst = 1'b1;
    q.delete();
    @(negedge clk);
    chk(adc_start_o == 1'b0 && irq_vec_o == 5'b0, "R1 reset mid-count",
        int'({irq_vec_o, adc_start_o}), 0);
    rst = 1'b0;
    quiet(30, "R1 no pulse after reset");

    // R2: each event line on its own bit, and a combined pattern
    cfg(3'd7, 0);
    ev(6'b000001, "R2");
    ev(6'b000010, "R2");
    ev(6'b000100, "R2");
    ev(6'b001000, "R2");
    ev(6'b010000, "R2");
    ev(6'b010101, "R2");

    // R3: two-level codes
    cfg(3'd0, 0);
    ev(6'b000001, "R3 code0 min");
    ev(6'b000010, "R3 code0 max");
    ev(6'b000100, "R3");
    quiet(3, "R3 code0 ignores 3L min");
    cfg(3'd1, 0);
    ev(6'b000001, "R3 code1 min");
    ev(6'b000010, "R3");
    quiet(3, "R3 code1 ignores max");
    cfg(3'd2, 0);
    ev(6'b000010, "R3 code2 max");
    ev(6'b000001, "R3");
    quiet(3, "R3 code2 ignores min");

    // R4: three-level codes
    cfg(3'd3, 0);
    ev(6'b000100, "R4 code3 min");
    ev(6'b001000, "R4 code3 max");
    ev(6'b000011, "R4");
    quiet(3, "R4 code3 ignores 2L");
    cfg(3'd4, 0);
    ev(6'b000100, "R4 code4 min");
    ev(6'b001000, "R4");
    quiet(3, "R4 code4 ignores max");
    cfg(3'd5, 0);
    ev(6'b001000, "R4 code5 max");
    ev(6'b000100, "R4");
    quiet(3, "R4 code5 ignores min");

    // R5: data mover
    cfg(3'd6, 0);
    ev(6'b010000, "R5 code6 done");
    ev(6'b001111, "R5");
    quiet(3, "R5 code6 ignores PWM");

    // R6: no source
    cfg(3'd7, 0);
    ev(6'b011111, "R6");
    quiet(5, "R6 code7 silent");

    // R11: debug fire under code 7 and with a delay
    ev(6'b100000, "R11 dbg code7");
    settle(2);
    cfg(3'd7, 4);
    ev(6'b100000, "R11 dbg delayed");
    settle(8);

    // R7: zero delay aligned with interrupt bit
    cfg(3'd0, 0);
    ev(6'b000001, "R7 zero delay");
    settle(2);

    // R8: nonzero delays
    cfg(3'd0, 1);
    ev(6'b000010, "R8 delay1");
    settle(4);
    cfg(3'd0, 5);
    ev(6'b000001, "R8 delay5");
    settle(10);
    cfg(3'd4, 37);
    ev(6'b000100, "R8 delay37");
    settle(45);

    // R9: retrigger restarts countdown, one pulse
    cfg(3'd1, 10);
    ev(6'b000001, "R9 first");
    settle(4);
    ev(6'b000001, "R9 restart");
    settle(15);
    quiet(5, "R9 single pulse");

    // R10: config change during countdown ignored
    cfg(3'd1, 8);
    ev(6'b000001, "R10 load");
    settle(2);
    cfg(3'd2, 2);
    ev(6'b000010, "R10");
    ev(6'b000001, "R10 restart held dly");
    settle(15);
    ev(6'b000010, "R10 new cfg idle");
    settle(6);
    quiet(4, "R10 settled");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule